// File: doc/BRIEF.md
# Counterflow Systolic FIR Convolver

This block computes a K-tap convolution of a stream of signed samples against K coefficients held inside a linear chain of K identical cells. Samples enter at the far end of the chain (cell K) and step one cell toward cell 1 on every clock. Partial sums step the other way, from cell 1 toward cell K. Because the two streams cross, the end cell that accepts the samples is also the one that hands out the finished sums. The samples are spaced two clocks apart, with zeros on the clocks in between.

Each cell has two stages. The first registers the product of its current sample and its coefficient. The second adds that product to the partial sum that arrived from the previous cell and passes the total on. Coefficients are loaded one at a time, through a write strobe with a cell index, while the stream is idle. A synchronous reset clears every register, the coefficients included. Sums are kept at full precision, so they never wrap.

The block has no state machine. The only sequencing is the fixed two-clock sample spacing that the producer keeps up, so no states or transitions need to be named.

Top module: `sysconv_array`

## Requirements
- R1: A rising edge with `rst` high clears every sample, product, partial-sum and coefficient register. In each following cycle `y_out` is 0 until a nonzero sample meets a nonzero coefficient.
- R2: Let sample a_i be driven on `x_in` in cycle c+2(i-1), with 0 on the cycles in between. Then `y_out` equals b_i = sum over j=1..K of a_(i+j-1)·w_j in cycle c+2(i-1)+2K. This is a latency of 2K clocks, which puts b_i on clock 2i+2K-1 when c=1. Samples outside the stream count as 0.
- R3: With that two-clock sample spacing, `y_out` is 0 in every cycle whose parity is opposite to the result cycles.
- R4: A write with `w_we`=1 and `w_idx`=u-1 (u in 1..K) stores `w_data` as coefficient w_u of cell u, starting with the next cycle. A write with `w_idx` ≥ K changes no coefficient. Without `w_we`, every coefficient holds its value.
- R5: Products are 2·DW bits wide and sums are 2·DW+ceil(log2 K) bits wide, in two's complement. `y_out` is exact even when every sample and every coefficient is -2^(DW-1), and no partial sum wraps.
- R6: Suppose one sample v is surrounded by zeros and is driven in cycle t. Then `y_out` is v·w_K in cycle t+2, v·w_(K-1) in cycle t+4, and so on, down to v·w_1 in cycle t+2K. It is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| x_in | input | DW | Signed sample entering cell K |
| w_we | input | 1 | Coefficient write strobe |
| w_idx | input | ceil(log2 K)+1 | Coefficient index; value u-1 selects cell u |
| w_data | input | DW | Signed coefficient value to store |
| y_out | output | 2·DW+ceil(log2 K) | Signed convolution result leaving cell K |

## Verification
In the end cell, a new sample enters in the same cycle that a finished sum leaves. Under the two-clock spacing, sample a_(i+K) arrives exactly when b_i is presented, so accepting a sample and handing out a result always share a cycle. The random stream provokes this on every result cycle. A scoreboard built from a reference convolution judges each output cycle, both the results and the zero gaps. A reset that arrives while sums are still in flight is the second collision, and it is judged by requiring zeros right afterwards and a silent impulse response.

// File: rtl/conv_pkg.sv
package conv_pkg;

    // Width of a partial sum that cannot wrap for k taps of dw-bit operands
    function automatic int acc_width(input int dw, input int k);
        return 2 * dw + $clog2(k);
    endfunction

    // Width of the coefficient index, one extra bit so out-of-range codes exist
    function automatic int index_width(input int k);
        return $clog2(k) + 1;
    endfunction

endpackage

// File: rtl/conv_wdecode.sv
module conv_wdecode #(
    parameter int K  = 4,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] idx,
    output logic [K-1:0]  cell_we
);

    always_comb begin
        for (int i = 0; i < K; i++) begin
            cell_we[i] = we && (idx == IW'(i));
        end
    end

    // R4: at most one cell is written per cycle
    assert_single_write_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cell_we));

    // R4: an index beyond the last cell enables no cell
    assert_range_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (we && (int'(idx) >= K)) |-> (cell_we == '0));

endmodule

// File: rtl/conv_cell.sv
module conv_cell #(
    parameter int DW = 8,
    parameter int AW = 18
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 w_we,
    input  logic signed [DW-1:0] w_data,
    input  logic signed [DW-1:0] smp_in,
    output logic signed [DW-1:0] smp_out,
    input  logic signed [AW-1:0] sum_in,
    output logic signed [AW-1:0] sum_out
);

    localparam int PW = 2 * DW;

    logic signed [DW-1:0] coef_q;
    logic signed [DW-1:0] smp_q;
    logic signed [PW-1:0] prod_q;
    logic signed [AW-1:0] sum_q;
    logic signed [AW-1:0] prod_ext;

    always_ff @(posedge clk) begin
        if (rst) begin
            coef_q <= '0;
        end else if (w_we) begin
            coef_q <= w_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_q  <= '0;
            prod_q <= '0;
            sum_q  <= '0;
        end else begin
            smp_q  <= smp_in;
            prod_q <= PW'(smp_q) * PW'(coef_q);
            sum_q  <= sum_in;
        end
    end

    assign prod_ext = AW'(prod_q);
    assign sum_out  = sum_q + prod_ext;
    assign smp_out  = smp_q;

    // R1: one cycle after reset every register of the cell is clear
    assert_cell_cleared_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (smp_q == '0 && prod_q == '0 && sum_q == '0 && coef_q == '0));

    // R4: the coefficient only moves on a write to this cell
    assert_coef_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !w_we |=> $stable(coef_q));

    // R5: adding two non-negative terms never yields a negative sum
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        (!prod_ext[AW-1] && !sum_q[AW-1]) |-> !sum_out[AW-1]);

    // R5: adding two negative terms never yields a non-negative sum
    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
        (prod_ext[AW-1] && sum_q[AW-1]) |-> sum_out[AW-1]);

endmodule

// File: rtl/sysconv_array.sv
module sysconv_array #(
    parameter int K  = 4,
    parameter int DW = 8
) (
    input  logic                                       clk,
    input  logic                                       rst,
    input  logic signed [DW-1:0]                       x_in,
    input  logic                                       w_we,
    input  logic [conv_pkg::index_width(K)-1:0]        w_idx,
    input  logic signed [DW-1:0]                       w_data,
    output logic signed [conv_pkg::acc_width(DW,K)-1:0] y_out
);

    localparam int AW = conv_pkg::acc_width(DW, K);
    localparam int IW = conv_pkg::index_width(K);

    logic [K-1:0]         cell_we;
    logic signed [DW-1:0] smp_link [1:K+1];
    logic signed [AW-1:0] sum_link [0:K];

    conv_wdecode #(.K(K), .IW(IW)) u_wdec (
        .clk     (clk),
        .rst     (rst),
        .we      (w_we),
        .idx     (w_idx),
        .cell_we (cell_we)
    );

    assign smp_link[K+1] = x_in;
    assign sum_link[0]   = '0;

    for (genvar u = 1; u <= K; u++) begin : g_cell
        conv_cell #(.DW(DW), .AW(AW)) u_cell (
            .clk     (clk),
            .rst     (rst),
            .w_we    (cell_we[u-1]),
            .w_data  (w_data),
            .smp_in  (smp_link[u+1]),
            .smp_out (smp_link[u]),
            .sum_in  (sum_link[u-1]),
            .sum_out (sum_link[u])
        );
    end

    assign y_out = sum_link[K];

    // R1: the result port is zero in the cycle after a reset
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (y_out == '0));

    // R3: two idle input cycles in a row after reset keep the end cell's fresh product out of the sum
    assert_gap_from_reset_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && x_in == '0) |=> (y_out == '0));

endmodule

// File: tb/sysconv_array_tb.sv
module sysconv_array_tb;

    localparam int K  = 4;
    localparam int DW = 8;
    localparam int IW = conv_pkg::index_width(K);
    localparam int AW = conv_pkg::acc_width(DW, K);
    localparam int HN = 4096;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic signed [DW-1:0] x_in = '0;
    logic                 w_we = 1'b0;
    logic [IW-1:0]        w_idx = '0;
    logic signed [DW-1:0] w_data = '0;
    logic signed [AW-1:0] y_out;

    int checks = 0;
    int errors = 0;
    int tc = 0;
    bit done = 1'b0;

    longint hist [0:HN-1];
    longint wm [0:K-1];
    longint exp_q [$];
    string  tag_q [$];

    always #10 clk = ~clk;

    sysconv_array #(.K(K), .DW(DW)) u_dut (
        .clk    (clk),
        .rst    (rst),
        .x_in   (x_in),
        .w_we   (w_we),
        .w_idx  (w_idx),
        .w_data (w_data),
        .y_out  (y_out)
    );

    // monitor: pop the expectation for the current cycle and compare
    task automatic monitor_cycle();
        longint ev;
        string  et;
        checks++;
        if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL scoreboard empty at cycle %0d: actual %0d expected none", tc, y_out);
        end else begin
            ev = exp_q.pop_front();
            et = tag_q.pop_front();
            if (longint'(y_out) != ev) begin
                errors++;
                $display("FAIL %s cycle %0d: y_out actual %0d expected %0d", et, tc, y_out, ev);
            end
        end
    endtask

    // driver: apply one cycle of stimulus and push the output due two cycles later
    task automatic step(input longint xv, input bit we, input int idx, input longint wd, input string tg);
        longint e;
        monitor_cycle();
        x_in   = DW'(xv);
        w_we   = we;
        w_idx  = IW'(idx);
        w_data = DW'(wd);
        if (tc < HN) hist[tc] = xv;
        if (we && idx >= 0 && idx < K) wm[idx] = wd;
        e = 0;
        for (int j = 1; j <= K; j++) begin
            int n;
            n = tc - 2 * (K - j);
            if (n >= 0 && n < HN) e += wm[j-1] * hist[n];
        end
        exp_q.push_back(e);
        tag_q.push_back(tg);
        @(negedge clk);
        tc++;
    endtask

    task automatic idle(input int n, input string tg);
        for (int i = 0; i < n; i++) step(0, 1'b0, 0, 0, tg);
    endtask

    task automatic apply_reset();
        rst  = 1'b1;
        x_in = '0;
        w_we = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < HN; i++) hist[i] = 0;
        for (int i = 0; i < K; i++) wm[i] = 0;
        exp_q.delete();
        tag_q.delete();
        exp_q.push_back(0); tag_q.push_back("R1");
        exp_q.push_back(0); tag_q.push_back("R1");
        tc = 0;
    endtask

    task automatic load_weights(input longint w0, input longint w1, input longint w2, input longint w3);
        step(0, 1'b1, 0, w0, "R4");
        step(0, 1'b1, 1, w1, "R4");
        step(0, 1'b1, 2, w2, "R4");
        step(0, 1'b1, 3, w3, "R4");
    endtask

    // one sample followed by a zero gap: result cycles tagged R2, gap cycles R3
    task automatic send(input longint v, input string tg);
        step(v, 1'b0, 0, 0, tg);
        step(0, 1'b0, 0, 0, "R3");
    endtask

    initial begin
        @(negedge clk);
        apply_reset();

        // R1: quiet after reset, coefficients zero so even a sample gives nothing
        idle(3, "R1");
        send(77, "R1");
        idle(2 * K + 2, "R1");

        // R4: load distinct coefficients w_1..w_K
        load_weights(3, -5, 7, 2);
        idle(2 * K + 2, "R4");

        // R6: impulse response comes out in reverse tap order, two clocks apart
        step(1, 1'b0, 0, 0, "R6");
        idle(2 * K + 4, "R6");
        step(-9, 1'b0, 0, 0, "R6");
        idle(2 * K + 4, "R6");

        // R2 and R3: random signed stream on alternate cycles
        for (int i = 0; i < 40; i++) begin
            send(longint'($signed(DW'($urandom_range(0, 255)))), "R2");
        end
        idle(2 * K + 2, "R2");

        // R4: out-of-range indices must leave the coefficients alone
        for (int i = K; i < (1 << IW); i++) step(0, 1'b1, i, 99, "R4");
        idle(2, "R4");
        step(1, 1'b0, 0, 0, "R4");
        idle(2 * K + 4, "R4");

        // R4: rewrite one coefficient only, then probe with a stream
        step(0, 1'b1, 1, -11, "R4");
        idle(2 * K + 2, "R4");
        for (int i = 0; i < 8; i++) send(longint'(i) - 3, "R4");
        idle(2 * K + 2, "R4");

        // R5: most negative operands everywhere, then mixed extremes
        load_weights(-128, -128, -128, -128);
        idle(2 * K + 2, "R5");
        for (int i = 0; i < K + 3; i++) send(-128, "R5");
        idle(2 * K + 2, "R5");
        load_weights(127, -128, 127, -128);
        idle(2 * K + 2, "R5");
        for (int i = 0; i < K + 3; i++) send((i % 2 == 0) ? -128 : 127, "R5");
        idle(2 * K + 2, "R5");

        // R1: reset while sums are still in flight
        load_weights(4, 6, -3, 5);
        for (int i = 0; i < 6; i++) send(longint'(i) * 17 - 40, "R2");
        apply_reset();
        idle(2 * K + 2, "R1");
        step(5, 1'b0, 0, 0, "R1");
        idle(2 * K + 4, "R1");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule